// File: doc/BRIEF.md
# Burst-Addressed Two-Port Synchronous RAM

This block is a word-organised static RAM with two identical access ports sharing one clock. Each port samples its address, write data and controls on the rising edge. Every port keeps its own address counter, which a user can load from the address pins, step forward, hold or force to zero. The counter feeds the storage directly, so long sequential bursts need only one address transfer. A port accesses memory only when both of its enables are asserted, one active-low and one active-high, so two devices can be banked with no extra decode. Each word is two 9-bit lanes, and each lane has its own enable.

Read data leaves a port either one edge after the address is taken (flow-through) or one edge later (pipelined). A static mode input on each port picks the timing. Each output lane comes with a drive flag. The flag and the data are gated without a clock by the port's output enable: a lane that is not driven shows zero with its flag low. Both ports may access any word in the same cycle. A read that meets a write from the other port at the same word returns the contents from before the write.

Top module: `burst_dual_port_ram`

## Requirements
- R1: When a port's load strobe is low at an edge and its clear input is high, that cycle's access uses the address pins, and the port's counter takes that value.
- R2: With clear and load strobe both high, a low step input advances the counter by one at the edge, and that cycle's access uses the advanced value. A high step input leaves the counter and the accessed word unchanged.
- R3: In a write cycle that steps the counter, the data is stored at the advanced address, not at the address used in the previous cycle.
- R4: A low clear input sets the counter to 0 and makes that same cycle's read or write target word 0. Clear takes priority over load, and load takes priority over step.
- R5: A cycle with the active-low enable high or the active-high enable low writes nothing, and its read result is never driven.
- R6: In pipelined mode, read data and its drive flags appear two edges after the address edge. After a deselected cycle, outputs drive again only once two enabled cycles have passed.
- R7: In flow-through mode, read data and its drive flags appear one edge after the address edge.
- R8: Lane 1 is bits 17:9 and lane 0 is bits 8:0. The active-low upper enable gates writes and read drive of lane 1, and the lower enable does the same for lane 0. A disabled lane keeps its stored bits and reads as zero with its flag low.
- R9: With the output enable high, every drive flag and every data bit of that port is zero, with no clock edge needed. Lowering it restores the registered result at once.
- R10: Stepping from the top address wraps the counter to 0.
- R11: A read on one port of a word that the other port writes in the same cycle returns the old contents.
- R12: Elaboration rejects an address width outside 4..15 and any lane count other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of counters and drive flags |
| a_pipe | input | 1 | Port A static mode: 1 pipelined, 0 flow-through |
| a_addr | input | ADDR_W | Port A address pins |
| a_load_n | input | 1 | Port A load strobe, active low |
| a_step_n | input | 1 | Port A counter step, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A write (low) or read (high) |
| a_hi_n | input | 1 | Port A lane 1 enable, active low |
| a_lo_n | input | 1 | Port A lane 0 enable, active low |
| a_drive_n | input | 1 | Port A output enable, active low, unclocked |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, zero on undriven lanes |
| a_rvalid | output | 2 | Port A per-lane drive flags |
| b_pipe | input | 1 | Port B static mode: 1 pipelined, 0 flow-through |
| b_addr | input | ADDR_W | Port B address pins |
| b_load_n | input | 1 | Port B load strobe, active low |
| b_step_n | input | 1 | Port B counter step, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B write (low) or read (high) |
| b_hi_n | input | 1 | Port B lane 1 enable, active low |
| b_lo_n | input | 1 | Port B lane 0 enable, active low |
| b_drive_n | input | 1 | Port B output enable, active low, unclocked |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, zero on undriven lanes |
| b_rvalid | output | 2 | Port B per-lane drive flags |

## Verification
The bench builds the block with a 4-bit address, which makes 16 words. At that depth, every word can be preloaded with a known value in a few cycles. Wrap-around from the top address is reached after a short burst. Random traffic also lands often on the word the other port is writing in the same cycle. The bench runs each port in both output modes, swapping the modes after a reset, so each timing path is checked from both sides of the array.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

   typedef enum logic [1:0] {
      CTR_HOLD  = 2'd0,
      CTR_STEP  = 2'd1,
      CTR_LOAD  = 2'd2,
      CTR_CLEAR = 2'd3
   } ctr_op_e;

   // clear beats load, load beats step
   function automatic ctr_op_e pick_op(input logic clr_n,
                                       input logic load_n,
                                       input logic step_n);
      if (!clr_n)  return CTR_CLEAR;
      if (!load_n) return CTR_LOAD;
      if (!step_n) return CTR_STEP;
      return CTR_HOLD;
   endfunction

endpackage

// File: rtl/bdp_addr_ctr.sv
module bdp_addr_ctr #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic              step_n,
   input  logic              clr_n,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] addr_now
);
   import bdp_pkg::*;

   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] cnt_nxt;
   ctr_op_e           op;

   assign op = pick_op(clr_n, load_n, step_n);

   always_comb begin
      unique case (op)
         CTR_CLEAR: cnt_nxt = '0;
         CTR_LOAD:  cnt_nxt = ext_addr;
         CTR_STEP:  cnt_nxt = cnt_q + ADDR_W'(1);
         default:   cnt_nxt = cnt_q;
      endcase
   end

   // the access of this cycle already uses the updated value
   assign addr_now = cnt_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (cnt_q == '0));

   assert_load_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !load_n) |=> (cnt_q == $past(ext_addr)));

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && !step_n) |=> (cnt_q == $past(cnt_q) + ADDR_W'(1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && step_n) |=> $stable(cnt_q));

endmodule

// File: rtl/bdp_store.sv
module bdp_store #(
   parameter int ADDR_W = 9,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                          clk,
   input  logic [1:0][ADDR_W-1:0]        addr,
   input  logic [1:0][LANES-1:0]         we,
   input  logic [1:0]                    re,
   input  logic [1:0][LANES*LANE_W-1:0]  wd,
   output logic [1:0][LANES*LANE_W-1:0]  rq
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q0, q1;

      // reads see the contents from before this edge's writes
      always_ff @(posedge clk) begin
         if (we[0][l]) mem[addr[0]] <= wd[0][l*LANE_W +: LANE_W];
         if (we[1][l]) mem[addr[1]] <= wd[1][l*LANE_W +: LANE_W];
         if (re[0])    q0 <= mem[addr[0]];
         if (re[1])    q1 <= mem[addr[1]];
      end

      assign rq[0][l*LANE_W +: LANE_W] = q0;
      assign rq[1][l*LANE_W +: LANE_W] = q1;
   end

endmodule

// File: rtl/bdp_read_stage.sv
module bdp_read_stage #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pipe,
   input  logic [LANES-1:0]        drv_in,
   input  logic [LANES*LANE_W-1:0] rq,
   input  logic                    drive_n,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic [LANES-1:0]        rvalid
);
   localparam int WORD_W = LANES * LANE_W;

   logic [LANES-1:0]  drv1_q, drv2_q;
   logic [WORD_W-1:0] d2_q;
   logic [LANES-1:0]  drv_sel;
   logic [WORD_W-1:0] d_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv1_q <= '0;
         drv2_q <= '0;
      end else begin
         drv1_q <= drv_in;
         drv2_q <= drv1_q;
      end
   end

   always_ff @(posedge clk) d2_q <= rq;

   assign drv_sel = pipe ? drv2_q : drv1_q;
   assign d_sel   = pipe ? d2_q   : rq;
   assign rvalid  = drv_sel & {LANES{~drive_n}};

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign rdata[l*LANE_W +: LANE_W] =
         rvalid[l] ? d_sel[l*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/burst_dual_port_ram.sv
module burst_dual_port_ram #(
   parameter int ADDR_W = 9,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    a_pipe,
   input  logic [ADDR_W-1:0]       a_addr,
   input  logic                    a_load_n,
   input  logic                    a_step_n,
   input  logic                    a_clr_n,
   input  logic                    a_en_n,
   input  logic                    a_en,
   input  logic                    a_wr_n,
   input  logic                    a_hi_n,
   input  logic                    a_lo_n,
   input  logic                    a_drive_n,
   input  logic [LANES*LANE_W-1:0] a_wdata,
   output logic [LANES*LANE_W-1:0] a_rdata,
   output logic [LANES-1:0]        a_rvalid,
   input  logic                    b_pipe,
   input  logic [ADDR_W-1:0]       b_addr,
   input  logic                    b_load_n,
   input  logic                    b_step_n,
   input  logic                    b_clr_n,
   input  logic                    b_en_n,
   input  logic                    b_en,
   input  logic                    b_wr_n,
   input  logic                    b_hi_n,
   input  logic                    b_lo_n,
   input  logic                    b_drive_n,
   input  logic [LANES*LANE_W-1:0] b_wdata,
   output logic [LANES*LANE_W-1:0] b_rdata,
   output logic [LANES-1:0]        b_rvalid
);
   localparam int WORD_W = LANES * LANE_W;
   localparam int PORTS  = 2;

   // R12: elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 15) begin : g_bad_addr_R12
      $error("address width must lie in 4..15");
   end
   if (LANES != 2) begin : g_bad_lanes_R12
      $error("exactly two byte lanes are supported");
   end

   logic [PORTS-1:0]              pipe, load_n, step_n, clr_n, en_n, en;
   logic [PORTS-1:0]              wr_n, hi_n, lo_n, drive_n, ok, re;
   logic [PORTS-1:0][ADDR_W-1:0]  ext, iaddr;
   logic [PORTS-1:0][WORD_W-1:0]  wd, rq, rdata;
   logic [PORTS-1:0][LANES-1:0]   we, drv, rvalid;

   assign pipe    = {b_pipe,    a_pipe};
   assign load_n  = {b_load_n,  a_load_n};
   assign step_n  = {b_step_n,  a_step_n};
   assign clr_n   = {b_clr_n,   a_clr_n};
   assign en_n    = {b_en_n,    a_en_n};
   assign en      = {b_en,      a_en};
   assign wr_n    = {b_wr_n,    a_wr_n};
   assign hi_n    = {b_hi_n,    a_hi_n};
   assign lo_n    = {b_lo_n,    a_lo_n};
   assign drive_n = {b_drive_n, a_drive_n};
   assign ext     = {b_addr,    a_addr};
   assign wd      = {b_wdata,   a_wdata};

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      logic [LANES-1:0] lane_on;

      assign ok[p]   = ~en_n[p] & en[p];
      assign lane_on = ~{hi_n[p], lo_n[p]};
      assign re[p]   = ok[p] & wr_n[p];
      assign we[p]   = (ok[p] & ~wr_n[p]) ? lane_on : '0;
      assign drv[p]  = re[p] ? lane_on : '0;

      bdp_addr_ctr #(.ADDR_W(ADDR_W)) i_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_n   (load_n[p]),
         .step_n   (step_n[p]),
         .clr_n    (clr_n[p]),
         .ext_addr (ext[p]),
         .addr_now (iaddr[p])
      );

      bdp_read_stage #(.LANE_W(LANE_W), .LANES(LANES)) i_rd (
         .clk     (clk),
         .rst_n   (rst_n),
         .pipe    (pipe[p]),
         .drv_in  (drv[p]),
         .rq      (rq[p]),
         .drive_n (drive_n[p]),
         .rdata   (rdata[p]),
         .rvalid  (rvalid[p])
      );

      assert_flow_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!pipe[p] && !ok[p]) |=> (rvalid[p] == '0));

      assert_pipe_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (pipe[p] && !ok[p]) |-> ##2 (rvalid[p] == '0));

      assert_drive_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
         drive_n[p] |-> (rdata[p] == '0));
   end

   bdp_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_store (
      .clk  (clk),
      .addr (iaddr),
      .we   (we),
      .re   (re),
      .wd   (wd),
      .rq   (rq)
   );

   assign a_rdata  = rdata[0];
   assign b_rdata  = rdata[1];
   assign a_rvalid = rvalid[0];
   assign b_rvalid = rvalid[1];

endmodule

// File: tb/test_burst_dual_port_ram.sv
module test_burst_dual_port_ram;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int WD    = 18;
   localparam int WDOG  = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] pipe, load_n, step_n, clr_n, en_n, en, wr_n, hi_n, lo_n, drive_n;
   logic [1:0][AW-1:0] addr;
   logic [1:0][WD-1:0] wdata, rdata;
   logic [1:0][1:0]    rvalid;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R1";

   // reference model state
   logic [WD-1:0] mem [DEPTH];
   logic [AW-1:0] cnt [2];
   logic [1:0]    fv [2];
   logic [1:0]    pv [2];
   logic [WD-1:0] fd [2];
   logic [WD-1:0] pd [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_dual_port_ram #(.ADDR_W(AW)) i_burst_dual_port_ram (
      .clk(clk), .rst_n(rst_n),
      .a_pipe(pipe[0]), .a_addr(addr[0]), .a_load_n(load_n[0]), .a_step_n(step_n[0]),
      .a_clr_n(clr_n[0]), .a_en_n(en_n[0]), .a_en(en[0]), .a_wr_n(wr_n[0]),
      .a_hi_n(hi_n[0]), .a_lo_n(lo_n[0]), .a_drive_n(drive_n[0]), .a_wdata(wdata[0]),
      .a_rdata(rdata[0]), .a_rvalid(rvalid[0]),
      .b_pipe(pipe[1]), .b_addr(addr[1]), .b_load_n(load_n[1]), .b_step_n(step_n[1]),
      .b_clr_n(clr_n[1]), .b_en_n(en_n[1]), .b_en(en[1]), .b_wr_n(wr_n[1]),
      .b_hi_n(hi_n[1]), .b_lo_n(lo_n[1]), .b_drive_n(drive_n[1]), .b_wdata(wdata[1]),
      .b_rdata(rdata[1]), .b_rvalid(rvalid[1])
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // compare both ports against the model, output enable applied now
   task automatic compare();
      for (int p = 0; p < 2; p++) begin
         logic [1:0]    v;
         logic [WD-1:0] d, e;
         v = pipe[p] ? pv[p] : fv[p];
         d = pipe[p] ? pd[p] : fd[p];
         if (drive_n[p]) v = 2'b00;
         e = {v[1] ? d[17:9] : 9'd0, v[0] ? d[8:0] : 9'd0};
         chk(cur_req, p ? "B flags" : "A flags", 32'(rvalid[p]), 32'(v));
         chk(cur_req, p ? "B data" : "A data", 32'(rdata[p]), 32'(e));
      end
   endtask

   task automatic tick();
      logic [AW-1:0] na [2];
      logic          ok [2];
      @(posedge clk);
      if (!rst_n) begin
         for (int p = 0; p < 2; p++) begin
            cnt[p] = '0; fv[p] = 2'b00; pv[p] = 2'b00;
         end
      end else begin
         for (int p = 0; p < 2; p++) begin
            if (!clr_n[p])       na[p] = '0;
            else if (!load_n[p]) na[p] = addr[p];
            else if (!step_n[p]) na[p] = cnt[p] + 1'b1;
            else                 na[p] = cnt[p];
            ok[p] = !en_n[p] && en[p];
            pv[p] = fv[p];
            pd[p] = fd[p];
            fv[p] = (ok[p] && wr_n[p]) ? ~{hi_n[p], lo_n[p]} : 2'b00;
            if (ok[p] && wr_n[p]) fd[p] = mem[na[p]];
         end
         for (int p = 0; p < 2; p++) begin
            if (ok[p] && !wr_n[p]) begin
               if (!hi_n[p]) mem[na[p]][17:9] = wdata[p][17:9];
               if (!lo_n[p]) mem[na[p]][8:0]  = wdata[p][8:0];
            end
            cnt[p] = na[p];
         end
      end
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int p);
      load_n[p] = 1'b1; step_n[p] = 1'b1; clr_n[p] = 1'b1;
      en_n[p] = 1'b1; en[p] = 1'b1; wr_n[p] = 1'b1;
      hi_n[p] = 1'b0; lo_n[p] = 1'b0; drive_n[p] = 1'b0;
      addr[p] = '0; wdata[p] = '0;
   endtask

   task automatic op(input int p, input logic ld, input logic st, input logic wr,
                     input logic [AW-1:0] a, input logic [WD-1:0] d);
      idle(p);
      en_n[p] = 1'b0;
      load_n[p] = ~ld; step_n[p] = ~st; wr_n[p] = ~wr;
      addr[p] = a; wdata[p] = d;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      chk("reset", "A flags", 32'(rvalid[0]), 0);
      chk("reset", "B flags", 32'(rvalid[1]), 0);
      rst_n = 1'b1;
   endtask

   task automatic rand_phase(input int wp, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         for (int p = 0; p < 2; p++) begin
            idle(p);
            clr_n[p]   = ($urandom_range(15) != 0);
            load_n[p]  = $urandom_range(1);
            step_n[p]  = $urandom_range(1);
            en_n[p]    = ($urandom_range(7) == 0);
            en[p]      = ($urandom_range(7) != 0);
            hi_n[p]    = ($urandom_range(3) == 0);
            lo_n[p]    = ($urandom_range(3) == 0);
            drive_n[p] = ($urandom_range(7) == 0);
            addr[p]    = AW'($urandom_range(DEPTH - 1));
            wdata[p]   = WD'($urandom);
            wr_n[p]    = (p == wp) ? $urandom_range(1) : 1'b1;
         end
         tick();
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      for (int p = 0; p < 2; p++) begin
         idle(p); fd[p] = '0; pd[p] = '0;
      end
      pipe = 2'b10;               // A flow-through, B pipelined
      do_reset();

      // preload every word with 3F000 | index
      cur_req = "R1";
      for (int i = 0; i < DEPTH; i++) begin
         op(0, 1, 0, 1, AW'(i), 18'h3F000 | 18'(i));
         tick();
      end
      idle(0);
      op(0, 1, 0, 0, 4'd9, '0); tick();
      chk("R1", "A load read 9", 32'(rdata[0]), 32'h3F009);

      // R3: burst write with step and hold
      cur_req = "R3";
      op(0, 1, 0, 1, 4'd3, 18'h00111); tick();
      op(0, 0, 1, 1, 4'd0, 18'h00222); tick();
      op(0, 0, 0, 1, 4'd0, 18'h00333); tick();
      op(0, 0, 1, 1, 4'd0, 18'h00444); tick();
      op(0, 1, 0, 0, 4'd4, '0); tick();
      chk("R3", "word 4 after hold rewrite", 32'(rdata[0]), 32'h00333);
      op(0, 1, 0, 0, 4'd5, '0); tick();
      chk("R3", "word 5 from stepped write", 32'(rdata[0]), 32'h00444);
      op(0, 1, 0, 0, 4'd3, '0); tick();
      chk("R3", "word 3 from loaded write", 32'(rdata[0]), 32'h00111);

      // R2: hold keeps the word, step moves on
      cur_req = "R2";
      op(0, 1, 0, 0, 4'd10, '0); tick();
      op(0, 0, 0, 0, 4'd0, '0); tick();
      chk("R2", "hold rereads word 10", 32'(rdata[0]), 32'h3F00A);
      op(0, 0, 1, 0, 4'd0, '0); tick();
      chk("R2", "step reads word 11", 32'(rdata[0]), 32'h3F00B);

      // R4: clear beats load, write lands at word 0
      cur_req = "R4";
      op(0, 1, 1, 1, 4'd9, 18'h2AAAA); clr_n[0] = 1'b0; tick();
      op(0, 1, 0, 0, 4'd9, '0); tick();
      chk("R4", "word 9 untouched", 32'(rdata[0]), 32'h3F009);
      op(0, 1, 0, 0, 4'd0, '0); tick();
      chk("R4", "word 0 written during clear", 32'(rdata[0]), 32'h2AAAA);

      // R10: wrap from top address
      cur_req = "R10";
      op(0, 1, 0, 0, 4'd15, '0); tick();
      chk("R10", "read top word", 32'(rdata[0]), 32'h3F00F);
      op(0, 0, 1, 0, 4'd0, '0); tick();
      chk("R10", "step wraps to word 0", 32'(rdata[0]), 32'h2AAAA);

      // R8: lane enables
      cur_req = "R8";
      op(0, 1, 0, 1, 4'd6, 18'h3FFFF); hi_n[0] = 1'b1; tick();
      op(0, 1, 0, 0, 4'd6, '0); lo_n[0] = 1'b1; tick();
      chk("R8", "upper lane only flags", 32'(rvalid[0]), 32'h2);
      chk("R8", "upper lane only data", 32'(rdata[0]), 32'h3F000);

      // R9: unclocked output enable
      cur_req = "R9";
      op(0, 1, 0, 0, 4'd6, '0); tick();
      drive_n[0] = 1'b1; #1;
      chk("R9", "flags off", 32'(rvalid[0]), 0);
      chk("R9", "data off", 32'(rdata[0]), 0);
      drive_n[0] = 1'b0; #1;
      chk("R9", "data back", 32'(rdata[0]), 32'h3F1FF);

      // R5 and R7: deselected write, flow-through timing
      cur_req = "R5";
      op(0, 1, 0, 1, 4'd2, '0); en_n[0] = 1'b1; tick();
      chk("R5", "no drive after deselect", 32'(rvalid[0]), 0);
      cur_req = "R7";
      op(0, 1, 0, 0, 4'd2, '0); tick();
      chk("R7", "flow-through one edge", 32'(rdata[0]), 32'h3F002);
      idle(0);

      // R11: B reads the word A writes in the same cycle
      cur_req = "R11";
      op(0, 1, 0, 1, 4'd7, 18'h12345);
      op(1, 1, 0, 0, 4'd7, '0); tick();
      idle(0); tick();
      chk("R11", "old data on other port", 32'(rdata[1]), 32'h3F007);
      op(1, 1, 0, 0, 4'd7, '0); tick(); tick();
      chk("R11", "new data next read", 32'(rdata[1]), 32'h12345);

      // R6: pipelined recovery after deselect
      cur_req = "R6";
      idle(1); tick();
      op(1, 1, 0, 0, 4'd1, '0); tick();
      chk("R6", "first enabled cycle undriven", 32'(rvalid[1]), 0);
      tick();
      chk("R6", "second enabled cycle drives", 32'(rvalid[1]), 32'h3);
      chk("R6", "pipelined data", 32'(rdata[1]), 32'h3F001);
      idle(1);

      // random traffic, one writer at a time, then modes swapped
      cur_req = "R2";
      rand_phase(0, 400);
      cur_req = "R4";
      rand_phase(1, 400);
      idle(0); idle(1);
      pipe = 2'b01;
      do_reset();
      cur_req = "R6";
      rand_phase(0, 400);
      cur_req = "R7";
      rand_phase(1, 400);

      summary();
      $finish;
   end

endmodule